// File: doc/BRIEF.md
# Control-Register Access Port over SMBus

This block is a standard-mode SMBus target that gives a system management controller access to a small file of eight control bytes. The bus clock and data lines are oversampled by the chip's system clock. The block decodes start and stop conditions, shifts bytes in and out, and acknowledges only when the address matches the one selected by two three-level strap inputs. It drives the data line only by pulling it low, and it never holds the clock line. Both the strap inputs and the register contents are plain signals on the chip side. The register contents go to the logic that gates the twelve clock outputs and selects the block-read length.

The first byte after the address is a command. Its top bit chooses between two transfer kinds. A single-byte transfer moves exactly one data byte. A counted block transfer carries a length byte ahead of the data. On a write, the master sends that length byte. On a read, the target returns it, and the value comes from a writable length register. Successive bytes of a transfer walk through consecutive register indices. Reading requires a repeated start after the command byte.

Top module: `ctl_smbus_target`

## Requirements
- R1: Each strap input is encoded as 0 = low, 1 = mid, 2 = high, and 3 is treated as high. For each strap pair (first, second), the 8-bit write address is: low/low D8, low/mid DA, low/high DE, mid/low C2, mid/mid C4, mid/high C6, high/low CA, high/mid CC, high/high CE. An address byte that matches the selected address is acknowledged.
- R2: An address byte that does not match is not acknowledged. This includes the general-call address 00. After such a byte the target drives nothing until the next start.
- R3: When command bit 7 is 1, bits 6:0 give the register index. Exactly one data byte is acknowledged and written to that index. A further data byte in the same transfer gets no acknowledge and changes nothing.
- R4: When command bit 7 is 0, the next byte is a length from 1 to 32 and is acknowledged. The data bytes that follow, up to that length, are each acknowledged and written at consecutive indices starting at bits 6:0 of the command.
- R5: A write length of 0, or of more than 32, gets no acknowledge, and no register changes for the rest of that transfer.
- R6: A single-byte read is a command with bit 7 set, then a repeated start, then the read address. It returns the register at the commanded index. A read address that is not preceded by a command in the same transfer is not acknowledged.
- R7: A block read is a command with bit 7 clear, then a repeated start and the read address. The target first returns the value of register 7 bits 4:0 as a length byte. It then returns the registers from the commanded index upward, one per byte, until the master answers with a NAK.
- R8: After reset, register 1 reads FF, register 2 reads 0F, register 5 reads 38, register 6 reads 71, register 7 reads 08, and registers 0, 3 and 4 read 00. The bench uses the parameter values REV_ID=3 and DEV_ID=71. Byte k of `regs_o` is bits 8k+7:8k.
- R9: Register 2 keeps only bits 3:0, register 7 keeps only bits 4:0, and all other bits of those registers read 0. Registers 0, 3, 4, 5 and 6 ignore writes. Register 5 is {REV_ID, 4'h8}, register 6 is DEV_ID, and indices 8 and above read 00.
- R10: A stop condition returns the target to idle. A start in the middle of a byte abandons that byte without writing it.
- R11: The target only ever pulls the data line low, and it changes its drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull data line low (open-drain enable) |
| strap_a_i | input | 2 | First address strap, decoded level |
| strap_b_i | input | 2 | Second address strap, decoded level |
| regs_o | output | 64 | Register file contents, byte k at bits 8k+7:8k |

## Verification
The assertions take for granted that the bus follows the protocol. They assume the master changes the data line only while the clock line is low, except when it creates a start or a stop, and that it never creates a start or a stop while the target holds the data line low. They also assume that every bus level lasts several system clocks, so that the two-stage synchronizer sees each edge. The bench master holds each quarter of a bus bit for ten system clocks and moves the data line only in the low half of the clock. It issues start, repeated start and stop only after the target has released the line, including the deliberately abandoned byte.

// File: rtl/ctl_smbus_pkg.sv
// Shared constants and the protocol phase type for the SMBus register port.
// Assumes an eight-entry byte register file and a block limit of 32 bytes.
package ctl_smbus_pkg;
    localparam int NREG      = 8;
    localparam int IDX_W     = $clog2(NREG);
    localparam int MAX_BLK   = 32;
    localparam int NUM_OE    = 12;
    localparam int CNT_W     = 5;
    localparam int CNT_RST   = 8;
    localparam int REG_OE_LO = 1;
    localparam int REG_OE_HI = 2;
    localparam int REG_VER   = 5;
    localparam int REG_DEV   = 6;
    localparam int REG_BCNT  = 7;

    typedef enum logic [2:0] {
        P_IDLE, P_ADDR, P_CMD, P_WCNT, P_WDAT, P_RCNT, P_RDAT, P_DROP
    } phase_t;
endpackage

// File: rtl/ctl_smbus_lines.sv
// Synchronizes SCL/SDA into the system clock domain and flags bus events.
// Assumes each bus level persists for at least three system clocks.
module ctl_smbus_lines (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_s, sda_s;
    logic       scl_p, sda_p;

    // Two-stage synchronizers plus one history stage, idle-high on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_s <= 2'b11;
            sda_s <= 2'b11;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_s <= {scl_s[0], scl_i};
            sda_s <= {sda_s[0], sda_i};
            scl_p <= scl_s[1];
            sda_p <= sda_s[1];
        end
    end

    assign scl_q    = scl_s[1];
    assign sda_q    = sda_s[1];
    assign scl_rise = scl_s[1] & ~scl_p;
    assign scl_fall = ~scl_s[1] & scl_p;
    assign start_ev = scl_s[1] & scl_p & sda_p & ~sda_s[1];
    assign stop_ev  = scl_s[1] & scl_p & ~sda_p & sda_s[1];
endmodule

// File: rtl/ctl_smbus_addr.sv
// Maps the two three-level straps to the 7-bit target address.
// Assumes strap code 0=low, 1=mid, 2=high; code 3 is read as high.
module ctl_smbus_addr (
    input  logic [1:0] strap_a_i,
    input  logic [1:0] strap_b_i,
    output logic [6:0] addr_o
);
    logic [1:0] la, lb;
    logic [7:0] wr_addr;

    // Fold the unused code onto "high".
    always_comb begin
        la = (strap_a_i == 2'd3) ? 2'd2 : strap_a_i;
        lb = (strap_b_i == 2'd3) ? 2'd2 : strap_b_i;
    end

    // Nine-entry address selection, expressed as 8-bit write addresses.
    always_comb begin
        unique case ({la, lb})
            4'b0000: wr_addr = 8'hD8;
            4'b0001: wr_addr = 8'hDA;
            4'b0010: wr_addr = 8'hDE;
            4'b0100: wr_addr = 8'hC2;
            4'b0101: wr_addr = 8'hC4;
            4'b0110: wr_addr = 8'hC6;
            4'b1000: wr_addr = 8'hCA;
            4'b1001: wr_addr = 8'hCC;
            default: wr_addr = 8'hCE;
        endcase
    end

    assign addr_o = wr_addr[7:1];
endmodule

// File: rtl/ctl_smbus_regs.sv
// Eight-byte control register file with masked writes and constant ID bytes.
// Assumes at most one write per cycle; indices past the file read as zero.
module ctl_smbus_regs
    import ctl_smbus_pkg::*;
#(
    parameter logic [3:0] VENDOR_ID = 4'h8,
    parameter logic [3:0] REV_ID    = 4'h3,
    parameter logic [7:0] DEV_ID    = 8'h71
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [6:0]          wr_idx,
    input  logic [7:0]          wr_data,
    input  logic [6:0]          rd_idx,
    output logic [7:0]          rd_data,
    output logic [CNT_W-1:0]    bcnt_o,
    output logic [8*NREG-1:0]   regs_o
);
    localparam int OE_HI_W = NUM_OE - 8;

    logic [7:0]         oe_lo;
    logic [OE_HI_W-1:0] oe_hi;
    logic [CNT_W-1:0]   bcnt;
    logic [7:0]         view [NREG];

    // Writable fields: low enables, high enables, block-read length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_lo <= '1;
            oe_hi <= '1;
            bcnt  <= CNT_W'(CNT_RST);
        end else if (wr_en) begin
            case (wr_idx)
                7'(REG_OE_LO): oe_lo <= wr_data;
                7'(REG_OE_HI): oe_hi <= wr_data[OE_HI_W-1:0];
                7'(REG_BCNT):  bcnt  <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Byte view of the file, reserved bits tied to zero.
    always_comb begin
        for (int k = 0; k < NREG; k++) view[k] = 8'h00;
        view[REG_OE_LO] = oe_lo;
        view[REG_OE_HI] = 8'(oe_hi);
        view[REG_VER]   = {REV_ID, VENDOR_ID};
        view[REG_DEV]   = DEV_ID;
        view[REG_BCNT]  = 8'(bcnt);
    end

    // Read port for the bus engine.
    assign rd_data = (rd_idx < 7'(NREG)) ? view[rd_idx[IDX_W-1:0]] : 8'h00;
    assign bcnt_o  = bcnt;

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[8*g +: 8] = view[g];
    end

    // R4
    oe_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 7'(REG_OE_LO)) |=> (regs_o[15:8] == $past(wr_data)));

    // R9
    bcnt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 7'(REG_BCNT)) |=> (regs_o[63:56] == {3'b000, $past(wr_data[4:0])}));
endmodule

// File: rtl/ctl_smbus_target.sv
// SMBus target engine: address match, command decode, byte and counted
// block transfers over the register file. Oversamples the bus; never
// stretches the clock; drives the data line only low.
// Assumes a protocol-conforming master and bus levels of 3+ system clocks.
module ctl_smbus_target
    import ctl_smbus_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h3,
    parameter logic [7:0] DEV_ID = 8'h71
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [1:0]        strap_a_i,
    input  logic [1:0]        strap_b_i,
    output logic [8*NREG-1:0] regs_o
);
    logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
    logic [6:0]       own_addr;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] bcnt;

    phase_t     phase, nxt, nph;
    logic [3:0] cnt;
    logic [7:0] shreg, txsh, wr_data;
    logic [6:0] idx, wr_idx;
    logic [5:0] remain;
    logic       blk, have_cmd, ack_en, mack, wr_en;
    logic       is_rd, active;

    ctl_smbus_lines i_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    ctl_smbus_addr i_addr (
        .strap_a_i(strap_a_i), .strap_b_i(strap_b_i), .addr_o(own_addr)
    );

    ctl_smbus_regs #(.REV_ID(REV_ID), .DEV_ID(DEV_ID)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(idx), .rd_data(rd_data),
        .bcnt_o(bcnt), .regs_o(regs_o)
    );

    // Phase classification and the phase taken when the ack slot ends.
    always_comb begin
        is_rd  = (phase == P_RCNT) || (phase == P_RDAT);
        active = (phase != P_IDLE) && (phase != P_DROP);
        nph    = (is_rd && !mack) ? P_DROP : nxt;
    end

    // Open-drain drive: our ack, or a zero bit of the byte being returned.
    assign sda_pull_o = ack_en || (is_rd && cnt <= 4'd8 && !txsh[7]);

    // Protocol engine: bits counted on SCL rise, decisions on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= P_IDLE; nxt <= P_IDLE; cnt <= '0;
            shreg <= '0; txsh <= '1; idx <= '0; remain <= '0;
            blk <= 1'b0; have_cmd <= 1'b0; ack_en <= 1'b0; mack <= 1'b0;
            wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_ev) begin
                phase <= P_IDLE; ack_en <= 1'b0; have_cmd <= 1'b0;
            end else if (start_ev) begin
                phase <= P_ADDR; cnt <= '0; ack_en <= 1'b0; txsh <= '1;
                have_cmd <= have_cmd && (phase == P_WCNT || phase == P_WDAT)
                            && (cnt <= 4'd1);
            end else if (active && scl_rise) begin
                if (cnt < 4'd8) begin
                    shreg <= {shreg[6:0], sda_q};
                    cnt   <= cnt + 4'd1;
                end else if (cnt == 4'd9) begin
                    mack <= ~sda_q;
                end
            end else if (active && scl_fall) begin
                if (cnt >= 4'd1 && cnt <= 4'd7) begin
                    txsh <= {txsh[6:0], 1'b1};
                end else if (cnt == 4'd8) begin
                    cnt <= 4'd9;
                    nxt <= P_DROP;
                    case (phase)
                        P_ADDR: if (shreg[7:1] == own_addr && (!shreg[0] || have_cmd)) begin
                            ack_en <= 1'b1;
                            nxt    <= shreg[0] ? (blk ? P_RCNT : P_RDAT) : P_CMD;
                        end
                        P_CMD: begin
                            ack_en <= 1'b1; blk <= ~shreg[7]; idx <= shreg[6:0];
                            have_cmd <= 1'b1; remain <= 6'd1;
                            nxt <= shreg[7] ? P_WDAT : P_WCNT;
                        end
                        P_WCNT: begin
                            have_cmd <= 1'b0;
                            if (shreg != 8'd0 && shreg <= 8'(MAX_BLK)) begin
                                ack_en <= 1'b1; remain <= shreg[5:0]; nxt <= P_WDAT;
                            end
                        end
                        P_WDAT: begin
                            have_cmd <= 1'b0;
                            if (remain != 6'd0) begin
                                ack_en <= 1'b1; wr_en <= 1'b1;
                                wr_idx <= idx; wr_data <= shreg;
                                idx <= idx + 7'd1; remain <= remain - 6'd1;
                                nxt <= P_WDAT;
                            end
                        end
                        P_RCNT, P_RDAT: nxt <= P_RDAT;
                        default: nxt <= P_DROP;
                    endcase
                end else if (cnt == 4'd9) begin
                    cnt <= '0; ack_en <= 1'b0; phase <= nph;
                    if (nph == P_RDAT) begin
                        txsh <= rd_data; idx <= idx + 7'd1;
                    end else if (nph == P_RCNT) begin
                        txsh <= 8'(bcnt);
                    end else begin
                        txsh <= '1;
                    end
                end
            end
        end
    end

    // R2
    addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && phase == P_ADDR) |-> (shreg[7:1] == own_addr));

    // R5
    wcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && phase == P_WCNT) |-> (shreg != 8'd0 && shreg <= 8'(MAX_BLK)));

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (phase == P_IDLE));

    // R11
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_q);
endmodule

// File: tb/test_ctl_smbus_target.sv
// Directed bench: a bit-level bus master, one task per scenario.
module test_ctl_smbus_target;
    localparam int Q = 10;
    localparam logic [7:0] ADDR_LL = 8'hD8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull;
    logic [1:0] sa = 2'd0, sb = 2'd0;
    logic [63:0] regs;
    wire  sda_line = sda_m & ~sda_pull;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [0:7];

    always #4 clk = ~clk;

    ctl_smbus_target #(.REV_ID(4'h3), .DEV_ID(8'h71)) i_ctl_smbus_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_a_i(sa), .strap_b_i(sb), .regs_o(regs)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic hq; repeat (Q) @(negedge clk); endtask
    task automatic bus_start; sda_m = 1; hq; scl_m = 1; hq; sda_m = 0; hq; scl_m = 0; hq; endtask
    task automatic bus_stop;  sda_m = 0; hq; scl_m = 1; hq; sda_m = 1; hq; endtask
    task automatic put_bit(input logic b); sda_m = b; hq; scl_m = 1; hq; hq; scl_m = 0; hq; endtask
    task automatic get_bit(output logic v); sda_m = 1; hq; scl_m = 1; hq; v = sda_line; hq; scl_m = 0; hq; endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(v);
        ack = !v;
    endtask

    task automatic recv(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(!mack);
    endtask

    // Model update from R9 masks.
    task automatic mwrite(input int idx, input logic [7:0] d);
        if (idx == 1) mdl[1] = d;
        else if (idx == 2) mdl[2] = d & 8'h0F;
        else if (idx == 7) mdl[7] = d & 8'h1F;
    endtask

    task automatic chk_regs(input string tag);
        for (int k = 0; k < 8; k++) chk(tag, regs[8*k +: 8], mdl[k]);
    endtask

    task automatic wr1(input logic [6:0] idx, input logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start; send(ADDR_LL, a1); send({1'b1, idx}, a2); send(d, a3); bus_stop;
        ok = a1 & a2 & a3;
    endtask

    task automatic rd1(input logic [6:0] idx, output logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start; send(ADDR_LL, a1); send({1'b1, idx}, a2);
        bus_start; send(ADDR_LL | 8'h01, a3); recv(1'b0, d); bus_stop;
        ok = a1 & a2 & a3;
    endtask

    task automatic blk_rd(input logic [6:0] idx, input int exp_n, input string tag);
        logic a1, a2, a3;
        logic [7:0] n, d;
        bus_start; send(ADDR_LL, a1); send({1'b0, idx}, a2);
        bus_start; send(ADDR_LL | 8'h01, a3);
        chk({tag, " acks"}, {a1, a2, a3}, 3'b111);
        recv(1'b1, n);
        chk({tag, " count"}, n, exp_n);
        for (int k = 0; k < exp_n; k++) begin
            recv(k < exp_n - 1, d);
            chk({tag, " data"}, d, (idx + k < 8) ? mdl[idx + k] : 8'h00);
        end
        bus_stop;
    endtask

    // R8: reset contents.
    task automatic t_reset;
        chk_regs("R8 reset");
        chk("R11 idle drive", sda_pull, 0);
    endtask

    // R3/R6: single-byte write and read back.
    task automatic t_byte;
        logic ok; logic [7:0] d;
        wr1(7'd1, 8'h5A, ok); mwrite(1, 8'h5A);
        chk("R3 acks", ok, 1);
        chk_regs("R3 regs");
        rd1(7'd1, d, ok);
        chk("R6 read", {ok, d}, {1'b1, 8'h5A});
        rd1(7'd6, d, ok);
        chk("R6 dev id", d, 8'h71);
    endtask

    // R9: reserved bits and read-only bytes.
    task automatic t_masks;
        logic ok; logic [7:0] d;
        wr1(7'd2, 8'hFF, ok); mwrite(2, 8'hFF);
        wr1(7'd5, 8'h00, ok);
        wr1(7'd0, 8'hFF, ok);
        chk_regs("R9 masks");
        rd1(7'd5, d, ok);
        chk("R9 ver byte", d, 8'h38);
        rd1(7'd20, d, ok);
        chk("R9 out of range", d, 8'h00);
    endtask

    // R3: a second data byte in byte mode is refused.
    task automatic t_byte_extra;
        logic a1, a2, a3, a4;
        bus_start; send(ADDR_LL, a1); send(8'h81, a2); send(8'h11, a3); send(8'h22, a4); bus_stop;
        mwrite(1, 8'h11);
        chk("R3 extra acks", {a1, a2, a3, a4}, 4'b1110);
        chk_regs("R3 extra regs");
    endtask

    // R4: counted block write across two registers.
    task automatic t_blk_wr;
        logic a1, a2, a3, a4, a5;
        bus_start; send(ADDR_LL, a1); send(8'h01, a2); send(8'h02, a3);
        send(8'hA5, a4); send(8'h3C, a5); bus_stop;
        mwrite(1, 8'hA5); mwrite(2, 8'h3C);
        chk("R4 acks", {a1, a2, a3, a4, a5}, 5'b11111);
        chk_regs("R4 regs");
    endtask

    // R5: length 0 and 33 refused, nothing written.
    task automatic t_bad_cnt;
        logic a1, a2, a3, a4;
        bus_start; send(ADDR_LL, a1); send(8'h01, a2); send(8'h00, a3); send(8'h99, a4); bus_stop;
        chk("R5 zero count", {a3, a4}, 2'b00);
        bus_start; send(ADDR_LL, a1); send(8'h01, a2); send(8'd33, a3); send(8'h77, a4); bus_stop;
        chk("R5 big count", {a3, a4}, 2'b00);
        chk_regs("R5 regs");
    endtask

    // R7: block reads with default and rewritten length.
    task automatic t_blk_rd;
        logic ok; logic [7:0] d;
        blk_rd(7'd0, 8, "R7 default");
        wr1(7'd7, 8'hE3, ok); mwrite(7, 8'hE3);
        rd1(7'd7, d, ok);
        chk("R9 length mask", d, 8'h03);
        blk_rd(7'd5, 3, "R7 short");
    endtask

    // R2/R6: wrong address, general call, read with no command.
    task automatic t_refuse;
        logic a;
        bus_start; send(8'hDA, a); bus_stop;
        chk("R2 wrong addr", a, 0);
        bus_start; send(8'h00, a); bus_stop;
        chk("R2 general call", a, 0);
        bus_start; send(ADDR_LL | 8'h01, a); bus_stop;
        chk("R6 read no cmd", a, 0);
    endtask

    // R10: start mid-byte abandons the byte.
    task automatic t_abort;
        logic a1, a2; logic ok; logic [7:0] d;
        bus_start; send(ADDR_LL, a1); send(8'h81, a2);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start; bus_stop;
        chk_regs("R10 abort regs");
        rd1(7'd1, d, ok);
        chk("R10 after abort", {ok, d}, {1'b1, mdl[1]});
    endtask

    // R1: all nine strap combinations.
    task automatic t_straps;
        logic a;
        logic [7:0] tbl [0:8];
        tbl = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4, 8'hC6, 8'hCA, 8'hCC, 8'hCE};
        for (int i = 0; i < 9; i++) begin
            sa = 2'(i / 3); sb = 2'(i % 3);
            bus_start; send(tbl[i], a); bus_stop;
            chk("R1 strap addr", a, 1);
        end
        sa = 2'd3; sb = 2'd3;
        bus_start; send(8'hCE, a); bus_stop;
        chk("R1 code 3 high", a, 1);
        sa = 2'd0; sb = 2'd0;
    endtask

    initial begin
        mdl = '{8'h00, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h38, 8'h71, 8'h08};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_byte;
        t_masks;
        t_byte_extra;
        t_blk_wr;
        t_bad_cnt;
        t_blk_rd;
        t_refuse;
        t_abort;
        t_straps;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule